// File: doc/BRIEF.md
# Three-Band Threshold Comparator Bank

This block watches a stream of conversion results. Each result carries the index of the comparator that should judge it. The selected comparator sorts the value into one of three bands using its own pair of thresholds: low, mid or high. Every comparator then drives two separate event paths. The trigger path emits a single-cycle pulse, and the interrupt path sets a sticky status bit.

Each path has its own 4-bit mode. The mode picks the band. It also picks whether the path fires on every sample in that band or only when the band is entered. For the low and high bands, the mode can add a hysteresis qualifier: the path fires only after the opposite band has been visited. Each path remembers the band of the previous sample and whether it is armed. Software can clear that history for either path on its own.

A small word-wide register port sets thresholds and modes, reads them back, reads the interrupt status and clears it by writing ones. The sample input follows valid/ready rules, but `s_ready` is tied high: the block takes one result every cycle and never applies back-pressure. A result is consumed on any clock edge where `s_valid` is high.

Top module: `cmp3band_bank`

## Requirements
- R1: A value v is low band when v <= low threshold, mid band when low threshold < v <= high threshold, and high band when v > high threshold. The comparison is unsigned.
- R2: `s_ready` is always 1. A qualifying sample for comparator k raises only `trig_pulse[k]`, for exactly the one cycle after the edge that accepted the sample. With no sample, `trig_pulse` is 0.
- R3: Mode encoding: bits [1:0] are the band (0 low, 1 mid, 2 high, 3 none), bit 2 selects "once" and bit 3 selects hysteresis. In an always mode, every sample in the selected band fires.
- R4: In a once mode, a sample fires only if it is in the selected band and its band differs from the previous sample's band for that path. After reset or a history clear, the previous band is unknown, so the first in-band sample fires.
- R5: Low band with hysteresis, always: a high-band sample arms the path. While armed, every low-band sample fires. A mid-band sample disarms the path. The path starts disarmed.
- R6: High band with hysteresis is the mirror of R5: a low-band sample arms the path and a mid-band sample disarms it.
- R7: Hysteresis with once fires on the first sample in the selected band while armed, and then disarms the path.
- R8: In the mid band the hysteresis bit has no effect. Band setting 3 (none) never fires.
- R9: The trigger path and the interrupt path of a comparator use independent modes. A firing interrupt path sets `irq_status[k]`, which then stays set.
- R10: Writing to the status address clears each status bit whose write-data bit is 1. If a set and a clear hit the same bit in the same cycle, the set wins.
- R11: Writing to a comparator's history address clears that comparator's trigger-path history when data bit 0 is 1, and its interrupt-path history when data bit 1 is 1. The other path is not touched.
- R12: Register map. Address bit [5] = 1 selects status. Otherwise address bits [4:2] give the comparator and bits [1:0] the register: 0 low threshold, 1 high threshold, 2 modes (trigger in [3:0], interrupt in [7:4]), 3 history clear (reads 0). After reset, thresholds are 0 and both modes are 4'h3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Always 1; the block never stalls |
| s_idx | input | IW (3) | Comparator selected for the sample |
| s_data | input | DW (12) | Conversion value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IW+3 (6) | Register address |
| reg_wdata | input | DW (12) | Register write data |
| reg_rdata | output | DW (12) | Register read data (combinational) |
| trig_pulse | output | NUM_CMP (8) | One-cycle trigger pulses |
| irq_status | output | NUM_CMP (8) | Sticky interrupt status |

## Verification
Boundary values at each threshold and one step past it are sent in the always modes. This separates the `<=` edges from `<` edges for all three bands. Runs of equal bands are compared with band changes to tell the once modes apart from the always modes. Sequences such as low-before-high, high-then-low and a mid excursion tell arming apart from disarming under hysteresis. A hysteresis bit set in the mid band must behave exactly like plain once. Separate comparators cover the interrupt side: a simultaneous set and clear, and a history clear on one path only, where the trigger path must stay silent while the interrupt path fires again.

// File: rtl/cmp3b_pkg.sv
package cmp3b_pkg;

  typedef enum logic [1:0] {
    BAND_LOW  = 2'd0,
    BAND_MID  = 2'd1,
    BAND_HIGH = 2'd2,
    BAND_NONE = 2'd3
  } band_e;

  // hyst: qualify by opposite band; once: fire only on band entry
  typedef struct packed {
    logic  hyst;
    logic  once;
    band_e band;
  } mode_t;

  localparam logic [3:0] MODE_OFF = 4'h3;

endpackage

// File: rtl/cmp3b_classify.sv
module cmp3b_classify
  import cmp3b_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic [DW-1:0] value,
  input  logic [DW-1:0] lo_thr,
  input  logic [DW-1:0] hi_thr,
  output band_e         band
);

  always_comb begin
    if (value <= lo_thr)      band = BAND_LOW;
    else if (value <= hi_thr) band = BAND_MID;
    else                      band = BAND_HIGH;
  end

endmodule

// File: rtl/cmp3b_path.sv
module cmp3b_path
  import cmp3b_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  smp_en,
  input  band_e band,
  input  mode_t mode,
  input  logic  hist_clr,
  output logic  fire
);

  band_e prev_q;
  logic  armed_q;
  logic  armed_d;
  logic  hyst_on;
  logic  in_sel;
  band_e opp;

  always_comb begin
    in_sel  = (mode.band != BAND_NONE) && (band == mode.band);
    hyst_on = mode.hyst && ((mode.band == BAND_LOW) || (mode.band == BAND_HIGH));
    case (mode.band)
      BAND_LOW:  opp = BAND_HIGH;
      BAND_HIGH: opp = BAND_LOW;
      default:   opp = BAND_NONE;
    endcase
    fire = smp_en && in_sel && (!mode.once || (band != prev_q)) && (!hyst_on || armed_q);
    if (!hyst_on)                 armed_d = 1'b0;
    else if (band == opp)         armed_d = 1'b1;
    else if (band == BAND_MID)    armed_d = 1'b0;
    else if (fire && mode.once)   armed_d = 1'b0;
    else                          armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= BAND_NONE;
      armed_q <= 1'b0;
    end else if (hist_clr) begin
      prev_q  <= BAND_NONE;
      armed_q <= 1'b0;
    end else if (smp_en) begin
      prev_q  <= band;
      armed_q <= armed_d;
    end
  end

  // R11: a history clear leaves the path unknown and disarmed
  p_hist_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clr |=> (prev_q == BAND_NONE) && !armed_q);

  // R5/R6: an opposite-band sample arms a hysteresis path
  p_arm_on_opposite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !hist_clr && hyst_on && (band == opp)) |=> armed_q);

  // R4: a once path records the band it just saw
  p_prev_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !hist_clr) |=> (prev_q == $past(band)));

endmodule

// File: rtl/cmp3band_bank.sv
module cmp3band_bank
  import cmp3b_pkg::*;
#(
  parameter int NUM_CMP = 8,   // power of two, at most DW
  parameter int DW      = 12,  // at least 8
  localparam int IW     = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
  localparam int AW     = IW + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [IW-1:0]      s_idx,
  input  logic [DW-1:0]      s_data,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic [NUM_CMP-1:0] trig_pulse,
  output logic [NUM_CMP-1:0] irq_status
);

  logic [DW-1:0] lo_thr    [NUM_CMP];
  logic [DW-1:0] hi_thr    [NUM_CMP];
  mode_t         trig_mode [NUM_CMP];
  mode_t         irq_mode  [NUM_CMP];

  logic          glb;
  logic [IW-1:0] widx;
  logic [1:0]    rsel;
  logic          st_clr;
  band_e         band_now;

  logic [NUM_CMP-1:0] trig_fire, irq_fire;
  logic [NUM_CMP-1:0] trig_q, irq_q;

  assign s_ready = 1'b1;
  assign glb     = reg_addr[AW-1];
  assign widx    = reg_addr[IW+1:2];
  assign rsel    = reg_addr[1:0];
  assign st_clr  = reg_wr && glb;

  cmp3b_classify #(.DW(DW)) u_cls (
    .value  (s_data),
    .lo_thr (lo_thr[s_idx]),
    .hi_thr (hi_thr[s_idx]),
    .band   (band_now)
  );

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic hit;
    logic clr_sel;
    assign hit     = s_valid && (s_idx == IW'(k));
    assign clr_sel = reg_wr && !glb && (widx == IW'(k)) && (rsel == 2'd3);

    cmp3b_path u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_en   (hit),
      .band     (band_now),
      .mode     (trig_mode[k]),
      .hist_clr (clr_sel && reg_wdata[0]),
      .fire     (trig_fire[k])
    );

    cmp3b_path u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_en   (hit),
      .band     (band_now),
      .mode     (irq_mode[k]),
      .hist_clr (clr_sel && reg_wdata[1]),
      .fire     (irq_fire[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_CMP; k++) begin
        lo_thr[k]    <= '0;
        hi_thr[k]    <= '0;
        trig_mode[k] <= mode_t'(MODE_OFF);
        irq_mode[k]  <= mode_t'(MODE_OFF);
      end
    end else if (reg_wr && !glb) begin
      case (rsel)
        2'd0: lo_thr[widx] <= reg_wdata;
        2'd1: hi_thr[widx] <= reg_wdata;
        2'd2: begin
          trig_mode[widx] <= mode_t'(reg_wdata[3:0]);
          irq_mode[widx]  <= mode_t'(reg_wdata[7:4]);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      irq_q  <= '0;
    end else begin
      trig_q <= trig_fire;
      irq_q  <= irq_fire | (irq_q & ~(st_clr ? reg_wdata[NUM_CMP-1:0] : '0));
    end
  end

  assign trig_pulse = trig_q;
  assign irq_status = irq_q;

  always_comb begin
    reg_rdata = '0;
    if (glb) begin
      reg_rdata[NUM_CMP-1:0] = irq_q;
    end else begin
      case (rsel)
        2'd0: reg_rdata = lo_thr[widx];
        2'd1: reg_rdata = hi_thr[widx];
        2'd2: reg_rdata[7:0] = {irq_mode[widx], trig_mode[widx]};
        default: ;
      endcase
    end
  end

  // R2: only one sample per cycle, so at most one pulse
  p_trig_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig_pulse));

  // R2: a pulse always follows an accepted sample
  p_trig_after_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_pulse) |-> $past(s_valid));

  // R10: status bits only fall through a status write
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !st_clr |=> (($past(irq_q) & ~irq_q) == '0));

endmodule

// File: tb/cmp3band_bank_tb.sv
`timescale 1ns/100ps
module cmp3band_bank_tb;
  localparam int N  = 8;
  localparam int DW = 12;
  localparam int IW = 3;
  localparam int AW = 6;
  localparam logic [AW-1:0] ST = 6'b100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [IW-1:0] s_idx = '0;
  logic [DW-1:0] s_data = '0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [N-1:0] trig_pulse, irq_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;
  item_t sb[$];
  logic took = 1'b0;

  always #2.5 clk = ~clk;

  cmp3band_bank u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_idx(s_idx), .s_data(s_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trig_pulse(trig_pulse), .irq_status(irq_status)
  );

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ca(input int i, input int s);
    return {1'b0, i[IW-1:0], s[1:0]};
  endfunction

  // monitor: compares trigger pulses with the scoreboard
  always @(posedge clk) took <= s_valid;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (took) begin
        item_t it;
        it = sb.pop_front();
        chk(DW'(trig_pulse), DW'(it.exp), it.tag);
      end else if (trig_pulse !== '0) begin
        chk(DW'(trig_pulse), '0, "R2 idle");
      end
    end
  end

  task automatic smp(input int idx, input int val, input bit e, input string tag);
    item_t it;
    it.exp = e ? N'(1) << idx : '0;
    it.tag = tag;
    sb.push_back(it);
    s_valid = 1'b1;
    s_idx   = IW'(idx);
    s_data  = DW'(val);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input int d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = DW'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input int e, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata, DW'(e), tag);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    chk(DW'(trig_pulse), '0, "R12 reset trig");
    chk(DW'(irq_status), '0, "R12 reset irq");
    chk(DW'(s_ready), 1, "R2 ready");
    rd(ca(0,2), 12'h033, "R12 reset mode");
    rd(ca(0,1), 0, "R12 reset hi");

    wr(ca(0,0), 100);
    wr(ca(0,1), 200);
    rd(ca(0,0), 100, "R12 lo readback");
    rd(ca(0,1), 200, "R12 hi readback");

    // R1/R3 low always
    wr(ca(0,2), 8'h30);
    rd(ca(0,2), 8'h30, "R12 mode readback");
    smp(0, 50, 1, "R1 low");
    smp(0, 100, 1, "R1 low edge");
    smp(0, 101, 0, "R1 lo+1");
    smp(0, 200, 0, "R1 mid");
    smp(0, 201, 0, "R1 high");
    smp(0, 30, 1, "R3 low always");
    smp(1, 50, 0, "R8 none");
    chk(DW'(irq_status), '0, "R8 irq none");
    // mid always
    wr(ca(0,2), 8'h31);
    smp(0, 100, 0, "R1 mid lo edge");
    smp(0, 101, 1, "R1 mid");
    smp(0, 200, 1, "R1 mid hi edge");
    smp(0, 201, 0, "R1 above mid");
    // high always
    wr(ca(0,2), 8'h32);
    smp(0, 200, 0, "R1 hi edge");
    smp(0, 201, 1, "R1 high");
    smp(0, 4095, 1, "R3 high always");
    // R4 high once
    wr(ca(0,2), 8'h36);
    smp(0, 300, 0, "R4 no change");
    smp(0, 50, 0, "R4 other band");
    smp(0, 250, 1, "R4 entry");
    smp(0, 260, 0, "R4 repeat");
    smp(0, 150, 0, "R4 mid");
    smp(0, 250, 1, "R4 reentry");
    wr(ca(0,3), 1);
    smp(0, 250, 1, "R11 R4 first after clear");
    // R8 mid once, hysteresis bit ignored
    wr(ca(0,2), 8'h3D);
    smp(0, 150, 1, "R8 mid entry");
    smp(0, 160, 0, "R8 mid repeat");
    smp(0, 50, 0, "R8 low");
    smp(0, 150, 1, "R8 mid reentry");
    // R5 low hysteresis always
    wr(ca(0,2), 8'h38);
    wr(ca(0,3), 1);
    smp(0, 50, 0, "R5 not armed");
    smp(0, 250, 0, "R5 arm");
    smp(0, 50, 1, "R5 armed low");
    smp(0, 60, 1, "R5 armed low again");
    smp(0, 150, 0, "R5 mid disarm");
    smp(0, 50, 0, "R5 disarmed");
    smp(0, 300, 0, "R5 rearm");
    smp(0, 40, 1, "R5 rearmed low");
    // R6 high hysteresis always
    wr(ca(0,2), 8'h3A);
    wr(ca(0,3), 1);
    smp(0, 300, 0, "R6 not armed");
    smp(0, 50, 0, "R6 arm");
    smp(0, 300, 1, "R6 armed high");
    smp(0, 150, 0, "R6 mid disarm");
    smp(0, 300, 0, "R6 disarmed");
    // R7 low hysteresis once
    wr(ca(0,2), 8'h3C);
    wr(ca(0,3), 1);
    smp(0, 250, 0, "R7 arm");
    smp(0, 50, 1, "R7 fire");
    smp(0, 40, 0, "R7 single");
    smp(0, 250, 0, "R7 rearm");
    smp(0, 50, 1, "R7 fire again");

    // R9/R10 interrupt path on comparator 2
    wr(ca(2,0), 100);
    wr(ca(2,1), 200);
    wr(ca(2,2), 8'h03);
    smp(2, 50, 0, "R9 trig off");
    chk(DW'(irq_status), 12'h004, "R9 irq set");
    smp(2, 150, 0, "R9 mid");
    chk(DW'(irq_status), 12'h004, "R9 sticky");
    rd(ST, 12'h004, "R12 status read");
    wr(ST, 12'h001);
    chk(DW'(irq_status), 12'h004, "R10 other bit");
    wr(ST, 12'h004);
    chk(DW'(irq_status), 12'h000, "R10 w1c");
    begin
      item_t it;
      it.exp = '0; it.tag = "R10 set-wins trig";
      sb.push_back(it);
      s_valid = 1'b1; s_idx = 3'd2; s_data = 12'd50;
      reg_wr = 1'b1; reg_addr = ST; reg_wdata = 12'h004;
      @(negedge clk);
      s_valid = 1'b0; reg_wr = 1'b0;
    end
    chk(DW'(irq_status), 12'h004, "R10 set wins");
    wr(ST, 12'h0FF);

    // R11 independent history clear on comparator 3
    wr(ca(3,0), 100);
    wr(ca(3,1), 200);
    wr(ca(3,2), 8'h66);
    smp(3, 300, 1, "R11 first trig");
    chk(DW'(irq_status), 12'h008, "R11 first irq");
    wr(ST, 12'h008);
    wr(ca(3,3), 2);
    rd(ca(3,3), 0, "R12 clear reads 0");
    smp(3, 300, 0, "R11 trig history kept");
    chk(DW'(irq_status), 12'h008, "R11 irq history cleared");
    wr(ST, 12'h008);
    wr(ca(3,3), 1);
    smp(3, 300, 1, "R11 trig history cleared");
    chk(DW'(irq_status), 12'h000, "R11 irq history kept");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule